// File: doc/BRIEF.md
# Interrupt Mask and DMA Request Router

This block sits inside a memory-card host controller and collects thirteen sticky event flags into one interrupt line for the processor and two request lines for the DMA engine. The command sequencer, the data engine and the clock control raise the flags with one-cycle pulses. The FIFO access paths, the clock-start action and generic per-bit clear pulses lower them. Software loads a thirteen-bit mask that hides chosen flags from the processor line.

A DMA-enable level comes from the controller's control register. While it is high, the receive-FIFO and transmit-FIFO service flags are taken away from the processor line. Each of these two flags then drives its own DMA request output. While it is low, both DMA lines stay low, and the two FIFO flags reach the processor line through the ordinary mask like any other flag. The flag and mask state is brought out as ports so that the surrounding register decode can return it on reads.

Top module: `irq_dma_router`

## Requirements
- R1: While rst_n is low, req_state, mask_state, cpu_irq, rx_dma_req and tx_dma_req are all zero.
- R2: A pulse on set_req[b] makes req_state[b] one on the next clock edge, and the bit stays one until a clear event for that bit.
- R3: A pulse on clr_req[b] makes req_state[b] zero on the next edge. When a set and a clear for the same bit arrive in the same cycle, the bit ends up one.
- R4: A pulse on rx_fifo_rd clears bit 5 (receive-FIFO service). A pulse on tx_fifo_wr clears bit 6 (transmit-FIFO service). Neither pulse touches any other bit.
- R5: clk_stop sets bit 4 (clock off) and clk_start clears it. When both arrive in the same cycle, bit 4 ends up one.
- R6: A cycle with mask_we high loads mask_wdata into mask_state. A mask bit of one hides that flag from cpu_irq.
- R7: While dma_en is high, bits 5 and 6 never raise cpu_irq, rx_dma_req follows bit 5 and tx_dma_req follows bit 6.
- R8: While dma_en is low, rx_dma_req and tx_dma_req are zero, and bits 5 and 6 reach cpu_irq through the mask like any other bit.
- R9: cpu_irq, rx_dma_req and tx_dma_req are registered. Each takes its new value at the clock edge after the edge on which req_state or mask_state changed, or after the edge on which dma_en was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_req | input | 13 | Per-bit set pulses from the sequencer and data engine |
| clr_req | input | 13 | Per-bit clear pulses |
| rx_fifo_rd | input | 1 | Host read of the receive FIFO; clears bit 5 |
| tx_fifo_wr | input | 1 | Host write of the transmit FIFO; clears bit 6 |
| clk_start | input | 1 | Card clock start; clears bit 4 |
| clk_stop | input | 1 | Card clock stop; sets bit 4 |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 13 | New mask value |
| dma_en | input | 1 | DMA mode level from the control register |
| req_state | output | 13 | Current request flags |
| mask_state | output | 13 | Current mask |
| cpu_irq | output | 1 | Processor interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The bench drives set and clear of the same bit in one cycle, including clock start and clock stop together. A design in which the clear won would lose an event. It toggles dma_en while the FIFO flags are set, alone and with every other flag masked. A design that forgot to hide bits 5 and 6 would leave the processor line high in DMA mode, and one that did not gate the DMA lines would raise a DMA request with DMA mode off. It also compares every output on every cycle against a behavioural model, so an output that took its value one cycle early or one cycle late is caught at the edge where it changes.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned REQ_COUNT   = 13;
  localparam int unsigned BIT_CLKOFF  = 4;
  localparam int unsigned BIT_RXSVC   = 5;
  localparam int unsigned BIT_TXSVC   = 6;

  typedef struct packed {
    logic irq;
    logic rx;
    logic tx;
  } route_out_t;
endpackage

// File: rtl/irq_evt_merge.sv
module irq_evt_merge #(
  parameter int unsigned NREQ       = 13,
  parameter int unsigned CLKOFF_BIT = 4,
  parameter int unsigned RX_BIT     = 5,
  parameter int unsigned TX_BIT     = 6
) (
  input  logic [NREQ-1:0] set_req,
  input  logic [NREQ-1:0] clr_req,
  input  logic            rx_fifo_rd,
  input  logic            tx_fifo_wr,
  input  logic            clk_start,
  input  logic            clk_stop,
  output logic [NREQ-1:0] set_vec,
  output logic [NREQ-1:0] clr_vec
);
  for (genvar b = 0; b < NREQ; b++) begin : g_bit
    if (b == CLKOFF_BIT) begin : g_clk
      assign set_vec[b] = set_req[b] | clk_stop;
      assign clr_vec[b] = clr_req[b] | clk_start;
    end else if (b == RX_BIT) begin : g_rx
      assign set_vec[b] = set_req[b];
      assign clr_vec[b] = clr_req[b] | rx_fifo_rd;
    end else if (b == TX_BIT) begin : g_tx
      assign set_vec[b] = set_req[b];
      assign clr_vec[b] = clr_req[b] | tx_fifo_wr;
    end else begin : g_plain
      assign set_vec[b] = set_req[b];
      assign clr_vec[b] = clr_req[b];
    end
  end
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int unsigned NREQ = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] set_vec,
  input  logic [NREQ-1:0] clr_vec,
  output logic [NREQ-1:0] req_q
);
  for (genvar b = 0; b < NREQ; b++) begin : g_cell
    logic flag_d;
    logic flag_en;

    always_comb begin
      flag_en = set_vec[b] | clr_vec[b];
      // a set beats a clear in the same cycle so no event is lost
      flag_d  = set_vec[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[b] <= 1'b0;
      end else if (flag_en) begin
        req_q[b] <= flag_d;
      end
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned NREQ = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [NREQ-1:0] wdata,
  output logic [NREQ-1:0] mask_q
);
  logic [NREQ-1:0] mask_d;

  always_comb begin
    mask_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (we) begin
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_router_pkg::*;
#(
  parameter int unsigned NREQ   = 13,
  parameter int unsigned RX_BIT = 5,
  parameter int unsigned TX_BIT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_q,
  input  logic [NREQ-1:0] mask_q,
  input  logic            dma_en,
  output route_out_t      out_q
);
  localparam logic [NREQ-1:0] ONE      = {{(NREQ-1){1'b0}}, 1'b1};
  localparam logic [NREQ-1:0] FIFO_SEL = (ONE << RX_BIT) | (ONE << TX_BIT);

  logic [NREQ-1:0] eff_mask;
  route_out_t      out_d;

  always_comb begin
    eff_mask  = mask_q | (dma_en ? FIFO_SEL : '0);
    out_d.irq = |(req_q & ~eff_mask);
    out_d.rx  = dma_en & req_q[RX_BIT];
    out_d.tx  = dma_en & req_q[TX_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      out_q <= out_d;
    end
  end
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NREQ       = REQ_COUNT,
  parameter int unsigned CLKOFF_BIT = BIT_CLKOFF,
  parameter int unsigned RX_BIT     = BIT_RXSVC,
  parameter int unsigned TX_BIT     = BIT_TXSVC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] set_req,
  input  logic [NREQ-1:0] clr_req,
  input  logic            rx_fifo_rd,
  input  logic            tx_fifo_wr,
  input  logic            clk_start,
  input  logic            clk_stop,
  input  logic            mask_we,
  input  logic [NREQ-1:0] mask_wdata,
  input  logic            dma_en,
  output logic [NREQ-1:0] req_state,
  output logic [NREQ-1:0] mask_state,
  output logic            cpu_irq,
  output logic            rx_dma_req,
  output logic            tx_dma_req
);
  logic [NREQ-1:0] set_vec;
  logic [NREQ-1:0] clr_vec;
  route_out_t      route_q;

  irq_evt_merge #(
    .NREQ(NREQ), .CLKOFF_BIT(CLKOFF_BIT), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)
  ) u_merge (
    .set_req(set_req), .clr_req(clr_req),
    .rx_fifo_rd(rx_fifo_rd), .tx_fifo_wr(tx_fifo_wr),
    .clk_start(clk_start), .clk_stop(clk_stop),
    .set_vec(set_vec), .clr_vec(clr_vec)
  );

  irq_req_bank #(.NREQ(NREQ)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .set_vec(set_vec), .clr_vec(clr_vec),
    .req_q(req_state)
  );

  irq_mask_reg #(.NREQ(NREQ)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .we(mask_we), .wdata(mask_wdata),
    .mask_q(mask_state)
  );

  irq_route #(.NREQ(NREQ), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)) u_route (
    .clk(clk), .rst_n(rst_n),
    .req_q(req_state), .mask_q(mask_state), .dma_en(dma_en),
    .out_q(route_q)
  );

  assign cpu_irq    = route_q.irq;
  assign rx_dma_req = route_q.rx;
  assign tx_dma_req = route_q.tx;
endmodule

// File: rtl/irq_dma_router_chk.sv
module irq_dma_router_chk #(
  parameter int unsigned NREQ       = 13,
  parameter int unsigned CLKOFF_BIT = 4,
  parameter int unsigned RX_BIT     = 5,
  parameter int unsigned TX_BIT     = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] set_req,
  input logic [NREQ-1:0] clr_req,
  input logic            rx_fifo_rd,
  input logic            tx_fifo_wr,
  input logic            clk_start,
  input logic            clk_stop,
  input logic            mask_we,
  input logic [NREQ-1:0] mask_wdata,
  input logic            dma_en,
  input logic [NREQ-1:0] req_state,
  input logic [NREQ-1:0] mask_state,
  input logic            cpu_irq,
  input logic            rx_dma_req,
  input logic            tx_dma_req
);
  logic [NREQ-1:0] any_clr;
  logic [NREQ-1:0] hide;
  always_comb begin
    any_clr = clr_req;
    any_clr[CLKOFF_BIT] = clr_req[CLKOFF_BIT] | clk_start;
    any_clr[RX_BIT]     = clr_req[RX_BIT] | rx_fifo_rd;
    any_clr[TX_BIT]     = clr_req[TX_BIT] | tx_fifo_wr;
    hide = mask_state;
    if (dma_en) begin
      hide[RX_BIT] = 1'b1;
      hide[TX_BIT] = 1'b1;
    end
  end

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (req_state == '0 && mask_state == '0 &&
                               !cpu_irq && !rx_dma_req && !tx_dma_req);
    end
  end

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(req_state) & ~$past(any_clr) & ~req_state) == '0));

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req != '0) |=> ((req_state & $past(set_req)) == $past(set_req)));

  // R4
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fifo_rd && !set_req[RX_BIT]) |=> !req_state[RX_BIT]);

  // R5
  clk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |=> req_state[CLKOFF_BIT]);

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_state == $past(mask_wdata)));

  // R8
  dma_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> (!rx_dma_req && !tx_dma_req));

  // R7
  dma_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_en |=> (rx_dma_req == $past(req_state[RX_BIT]) &&
                tx_dma_req == $past(req_state[TX_BIT])));

  // R9
  irq_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_irq == $past(|(req_state & ~hide))));
endmodule

bind irq_dma_router irq_dma_router_chk #(
  .NREQ(NREQ), .CLKOFF_BIT(CLKOFF_BIT), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req),
  .rx_fifo_rd(rx_fifo_rd), .tx_fifo_wr(tx_fifo_wr),
  .clk_start(clk_start), .clk_stop(clk_stop),
  .mask_we(mask_we), .mask_wdata(mask_wdata), .dma_en(dma_en),
  .req_state(req_state), .mask_state(mask_state),
  .cpu_irq(cpu_irq), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
);

// File: tb/sim_irq_dma_router.sv
`timescale 1ns/1ps
module sim_irq_dma_router;
  localparam int N = 13;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] set_req, clr_req, mask_wdata;
  logic         rx_fifo_rd, tx_fifo_wr, clk_start, clk_stop, mask_we, dma_en;
  logic [N-1:0] req_state, mask_state;
  logic         cpu_irq, rx_dma_req, tx_dma_req;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  // behavioural model state
  int unsigned m_req, m_mask;
  bit m_irq, m_rx, m_tx;

  always #10 clk = ~clk;

  irq_dma_router u0 (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req),
    .rx_fifo_rd(rx_fifo_rd), .tx_fifo_wr(tx_fifo_wr),
    .clk_start(clk_start), .clk_stop(clk_stop),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .dma_en(dma_en),
    .req_state(req_state), .mask_state(mask_state),
    .cpu_irq(cpu_irq), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
  );

  task automatic chk(string tag, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk({phase, " req_state"}, req_state, m_req);
    chk({phase, " mask_state"}, mask_state, m_mask);
    chk({phase, " cpu_irq"}, cpu_irq, m_irq);
    chk({phase, " rx_dma_req"}, rx_dma_req, m_rx);
    chk({phase, " tx_dma_req"}, tx_dma_req, m_tx);
  endtask

  task automatic idle_inputs();
    set_req = '0; clr_req = '0; mask_wdata = '0;
    rx_fifo_rd = 0; tx_fifo_wr = 0; clk_start = 0; clk_stop = 0; mask_we = 0;
  endtask

  // one clock: model next state from the driven inputs, then compare after the edge
  task automatic cyc();
    int unsigned hid, sets, clrs, n_req, n_mask;
    bit n_irq, n_rx, n_tx;
    hid   = m_mask | (dma_en ? 32'h60 : 32'h0);
    n_irq = ((m_req & ~hid) & 32'h1fff) != 0;
    n_rx  = dma_en && m_req[5];
    n_tx  = dma_en && m_req[6];
    sets  = set_req | (clk_stop ? 32'h10 : 0);
    clrs  = clr_req | (clk_start ? 32'h10 : 0) | (rx_fifo_rd ? 32'h20 : 0)
                    | (tx_fifo_wr ? 32'h40 : 0);
    n_req  = (m_req & ~clrs) | sets;
    n_mask = mask_we ? mask_wdata : m_mask;
    @(negedge clk);
    m_req = n_req; m_mask = n_mask; m_irq = n_irq; m_rx = n_rx; m_tx = n_tx;
    compare_all();
    idle_inputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    dma_en = 0;
    rst_n = 0;
    m_req = 0; m_mask = 0; m_irq = 0; m_rx = 0; m_tx = 0;
    // R1: drive activity during reset; nothing may move
    set_req = '1; mask_we = 1; mask_wdata = '1; dma_en = 1;
    repeat (3) @(negedge clk);
    compare_all();
    idle_inputs(); dma_en = 0;
    @(negedge clk);
    rst_n = 1;
    cyc();

    // R2: set a few bits, they stay
    phase = "R2";
    set_req = 13'h0205; cyc();   // req updates, irq not yet (R9)
    cyc(); cyc();
    chk("R2 explicit sticky", req_state, 13'h0205);
    chk("R9 irq after one cycle", cpu_irq, 1);

    // R6: mask hides
    phase = "R6";
    mask_we = 1; mask_wdata = 13'h0205; cyc(); cyc();
    chk("R6 all masked irq low", cpu_irq, 0);
    mask_we = 1; mask_wdata = 13'h0005; cyc(); cyc();
    chk("R6 bit 9 unmasked", cpu_irq, 1);

    // R3: clear, and same-cycle set+clear
    phase = "R3";
    clr_req = 13'h0200; cyc(); cyc();
    chk("R3 cleared irq low", cpu_irq, 0);
    set_req = 13'h0800; clr_req = 13'h0801; cyc(); cyc();
    chk("R3 set beats clear", req_state, 13'h0804);

    // R5: clock off flag
    phase = "R5";
    mask_we = 1; mask_wdata = 13'h0000; clr_req = '1; cyc(); cyc();
    clk_stop = 1; cyc(); cyc();
    chk("R5 stop sets bit4", req_state, 13'h0010);
    clk_start = 1; cyc(); cyc();
    chk("R5 start clears bit4", req_state, 13'h0000);
    clk_start = 1; clk_stop = 1; cyc(); cyc();
    chk("R5 stop wins", req_state, 13'h0010);
    clr_req = 13'h0010; cyc();

    // R8: DMA off, FIFO bits go to irq
    phase = "R8";
    set_req = 13'h0060; cyc(); cyc();
    chk("R8 fifo bits on irq", cpu_irq, 1);
    chk("R8 rx dma low", rx_dma_req, 0);
    // R4: FIFO accesses clear only their own bit
    phase = "R4";
    rx_fifo_rd = 1; cyc(); cyc();
    chk("R4 rx read clears bit5", req_state, 13'h0040);
    tx_fifo_wr = 1; set_req = 13'h0001; cyc(); cyc();
    chk("R4 tx write clears bit6", req_state, 13'h0001);

    // R7: DMA on
    phase = "R7";
    clr_req = '1; cyc();
    dma_en = 1;
    set_req = 13'h0060; cyc(); cyc();
    chk("R7 fifo hidden from irq", cpu_irq, 0);
    chk("R7 rx dma high", rx_dma_req, 1);
    chk("R7 tx dma high", tx_dma_req, 1);
    rx_fifo_rd = 1; cyc(); cyc();
    chk("R7 rx dma drops", rx_dma_req, 0);
    set_req = 13'h0100; cyc(); cyc();
    chk("R7 other bit still on irq", cpu_irq, 1);

    // R9: toggle dma_en and mask, per-cycle timing
    phase = "R9";
    dma_en = 0; cyc(); cyc();
    dma_en = 1; cyc();
    mask_we = 1; mask_wdata = 13'h0100; cyc(); cyc();
    dma_en = 0; cyc(); cyc();
    for (int i = 0; i < 40; i++) begin
      set_req = 13'((i * 37) & 13'h1fff) & 13'(1 << (i % 13));
      clr_req = 13'(1 << ((i * 5) % 13));
      rx_fifo_rd = (i % 3) == 0;
      tx_fifo_wr = (i % 4) == 1;
      clk_stop = (i % 5) == 2;
      clk_start = (i % 7) == 3;
      mask_we = (i % 6) == 0;
      mask_wdata = 13'((i * 1237) & 13'h1fff);
      dma_en = (i % 8) > 3;
      cyc();
    end
    dma_en = 0; cyc(); cyc();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule